// File: doc/BRIEF.md
# Bidirectional GPIO port controller

This block controls eight general-purpose I/O pins from a byte-wide register bus. Software reaches three registers. The first is a write-only direction register, where a 1 turns a pin into an output. The second is a read/write output data register. The third is a read-only pin-state register. The block drives a per-pin output value and a per-pin output enable toward the pad ring. It also brings the pad input levels in through a synchronizer.

Two kinds of reset are handled separately. A hard reset, for power-on or hardware standby, clears everything. A soft reset, for a manual reset or software standby, keeps the direction and data registers. It clears only the latched peripheral ownership vector. An on-chip timer can claim individual pins through that vector. While it owns a pin, the timer supplies that pin's output enable and output value.

Top module: `gpio_byte_port`

## Requirements
- R1: While `rst_hard_n` is low, the direction and data registers are 0x00, so `pad_oe_o` and `pad_do_o` read 0x00 at once. A data read after release returns 0x00.
- R2: A write with `bus_addr_i` = 0xFEB1 loads the direction register. It shows on `pad_oe_o` after the clock edge that samples the write.
- R3: A read at 0xFEB1 returns the fixed pattern 0xFF, because the direction register is write-only.
- R4: Address 0xFF61 is the data register. A write shows on `pad_do_o` after its clock edge, for input pins too. A read returns the stored value.
- R5: Asserting `rst_soft_i` leaves the direction and data registers unchanged.
- R6: A read at 0xFF51 returns, for each bit, the data register bit if the pin is an output. If the pin is an input, it returns the pad level after a two-flop synchronizer. A level change on `pad_in_i` appears on the second clock edge after it is applied.
- R7: `periph_en_i` is latched on each clock edge. From the edge after a bit is latched as 1, that pin's `pad_oe_o` and `pad_do_o` follow `periph_oe_i` and `periph_do_i`.
- R8: A clock edge with `rst_soft_i` high clears the latched ownership vector. After that edge, all pins follow the direction and data registers again.
- R9: Writes to the pin-state address and to unmapped addresses change no register. Reads of unmapped addresses return 0x00. `bus_rdata_o` is 0x00 whenever `bus_rd_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_hard_n | input | 1 | Power-on / hardware standby reset, active low, asynchronous |
| rst_soft_i | input | 1 | Manual reset / software standby, active high, synchronous |
| bus_addr_i | input | 16 | Register address (low 16 bits) |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational |
| pad_in_i | input | 8 | Pad input levels |
| pad_oe_o | output | 8 | Per-pin output enable |
| pad_do_o | output | 8 | Per-pin output value |
| periph_en_i | input | 8 | Peripheral ownership request per pin |
| periph_oe_i | input | 8 | Peripheral output enable |
| periph_do_i | input | 8 | Peripheral output value |

## Verification
Register writes and ownership changes land on the first clock edge after the strobe. The bench therefore drives each input on a falling edge and reads the pins on the next falling edge. Read data is combinational, so a read is sampled a few nanoseconds after the address is driven, before any edge passes. The input synchronizer needs two edges. The bench reads the pin-state register once after one edge and expects the old level, then again after the second edge and expects the new one. The hard reset is asynchronous, so its effect on the pins is checked within the same low phase in which it is asserted.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_DIR  = 2'd1,
      SEL_DAT  = 2'd2,
      SEL_PIN  = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
   import gpio_port_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter logic [ADDR_W-1:0] A_DIR = 'hFEB1,
   parameter logic [ADDR_W-1:0] A_DAT = 'hFF61,
   parameter logic [ADDR_W-1:0] A_PIN = 'hFF51
) (
   input  logic [ADDR_W-1:0] addr_i,
   output reg_sel_e          sel_o
);
   always_comb begin
      if (addr_i == A_DIR)      sel_o = SEL_DIR;
      else if (addr_i == A_DAT) sel_o = SEL_DAT;
      else if (addr_i == A_PIN) sel_o = SEL_PIN;
      else                      sel_o = SEL_NONE;
   end
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_hard_n,
   input  logic         wr_dir_i,
   input  logic         wr_dat_i,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] dir_q_o,
   output logic [W-1:0] dat_q_o
);
   // soft reset is deliberately not an input: both registers survive it
   always_ff @(posedge clk or negedge rst_hard_n) begin
      if (!rst_hard_n) begin
         dir_q_o <= '0;
         dat_q_o <= '0;
      end else begin
         if (wr_dir_i) dir_q_o <= wdata_i;
         if (wr_dat_i) dat_q_o <= wdata_i;
      end
   end

   a_r2_dir_load: assert property (@(posedge clk) disable iff (!rst_hard_n)
      wr_dir_i |=> dir_q_o == $past(wdata_i));
   a_r4_dat_load: assert property (@(posedge clk) disable iff (!rst_hard_n)
      wr_dat_i |=> dat_q_o == $past(wdata_i));
   a_r5_dir_hold: assert property (@(posedge clk) disable iff (!rst_hard_n)
      !wr_dir_i |=> $stable(dir_q_o));
   a_r9_dat_hold: assert property (@(posedge clk) disable iff (!rst_hard_n)
      !wr_dat_i |=> $stable(dat_q_o));
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int unsigned W      = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_hard_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_hard_n) begin
         if (!rst_hard_n)  stage_q[s] <= '0;
         else if (s == 0)  stage_q[s] <= d_i;
         else              stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
   end
   assign q_o = stage_q[STAGES-1];

   if (STAGES == 2) begin : g_chk2
      logic [1:0] edges_q;
      always_ff @(posedge clk or negedge rst_hard_n) begin
         if (!rst_hard_n)             edges_q <= '0;
         else if (edges_q != 2'd2)    edges_q <= edges_q + 2'd1;
      end
      a_r6_two_edge_delay: assert property (@(posedge clk) disable iff (!rst_hard_n)
         (edges_q == 2'd2) |-> q_o == $past(d_i, 2));
   end
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
   parameter int unsigned W          = 8,
   parameter bit          HAS_PERIPH = 1'b1
) (
   input  logic [W-1:0] dir_i,
   input  logic [W-1:0] dat_i,
   input  logic [W-1:0] own_i,
   input  logic [W-1:0] p_oe_i,
   input  logic [W-1:0] p_do_i,
   output logic [W-1:0] oe_o,
   output logic [W-1:0] do_o
);
   for (genvar i = 0; i < W; i++) begin : g_pin
      if (HAS_PERIPH) begin : g_ovr
         assign oe_o[i] = own_i[i] ? p_oe_i[i] : dir_i[i];
         assign do_o[i] = own_i[i] ? p_do_i[i] : dat_i[i];
      end else begin : g_plain
         assign oe_o[i] = dir_i[i];
         assign do_o[i] = dat_i[i];
      end
   end
endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux
   import gpio_port_pkg::*;
#(
   parameter int unsigned W = 8,
   parameter logic [W-1:0] DIR_FILL = '1
) (
   input  logic         rd_i,
   input  reg_sel_e     sel_i,
   input  logic [W-1:0] dir_i,
   input  logic [W-1:0] dat_i,
   input  logic [W-1:0] sync_i,
   output logic [W-1:0] rdata_o
);
   logic [W-1:0] pin_view;
   assign pin_view = (dir_i & dat_i) | (~dir_i & sync_i);

   always_comb begin
      rdata_o = '0;
      if (rd_i) begin
         unique case (sel_i)
            SEL_DIR:  rdata_o = DIR_FILL;
            SEL_DAT:  rdata_o = dat_i;
            SEL_PIN:  rdata_o = pin_view;
            default:  rdata_o = '0;
         endcase
      end
   end
endmodule

// File: rtl/gpio_byte_port.sv
module gpio_byte_port
   import gpio_port_pkg::*;
#(
   parameter int unsigned PIN_W       = 8,
   parameter int unsigned ADDR_W      = 16,
   parameter logic [ADDR_W-1:0] ADDR_DIR = 'hFEB1,
   parameter logic [ADDR_W-1:0] ADDR_DAT = 'hFF61,
   parameter logic [ADDR_W-1:0] ADDR_PIN = 'hFF51,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [PIN_W-1:0] DIR_RD_FILL = '1,
   parameter bit          HAS_PERIPH  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_hard_n,
   input  logic              rst_soft_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic              bus_wr_i,
   input  logic              bus_rd_i,
   input  logic [PIN_W-1:0]  bus_wdata_i,
   output logic [PIN_W-1:0]  bus_rdata_o,
   input  logic [PIN_W-1:0]  pad_in_i,
   output logic [PIN_W-1:0]  pad_oe_o,
   output logic [PIN_W-1:0]  pad_do_o,
   input  logic [PIN_W-1:0]  periph_en_i,
   input  logic [PIN_W-1:0]  periph_oe_i,
   input  logic [PIN_W-1:0]  periph_do_i
);
   if (PIN_W < 1) begin : g_bad_w
      $error("PIN_W must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (ADDR_DIR == ADDR_DAT || ADDR_DIR == ADDR_PIN || ADDR_DAT == ADDR_PIN) begin : g_bad_map
      $error("register addresses must differ");
   end

   reg_sel_e          sel;
   logic [PIN_W-1:0]  dir_q, dat_q, sync_q, own_q;
   logic              wr_dir, wr_dat;

   gpio_addr_dec #(.ADDR_W(ADDR_W), .A_DIR(ADDR_DIR), .A_DAT(ADDR_DAT), .A_PIN(ADDR_PIN))
      u_dec (.addr_i(bus_addr_i), .sel_o(sel));

   // pin-state address is read-only: its write decode goes nowhere
   assign wr_dir = bus_wr_i && (sel == SEL_DIR);
   assign wr_dat = bus_wr_i && (sel == SEL_DAT);

   gpio_regfile #(.W(PIN_W)) u_regs (
      .clk(clk), .rst_hard_n(rst_hard_n),
      .wr_dir_i(wr_dir), .wr_dat_i(wr_dat), .wdata_i(bus_wdata_i),
      .dir_q_o(dir_q), .dat_q_o(dat_q));

   gpio_in_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_hard_n(rst_hard_n), .d_i(pad_in_i), .q_o(sync_q));

   if (HAS_PERIPH) begin : g_own
      always_ff @(posedge clk or negedge rst_hard_n) begin
         if (!rst_hard_n)     own_q <= '0;
         else if (rst_soft_i) own_q <= '0;
         else                 own_q <= periph_en_i;
      end
   end else begin : g_no_own
      assign own_q = '0;
   end

   gpio_pin_mux #(.W(PIN_W), .HAS_PERIPH(HAS_PERIPH)) u_pins (
      .dir_i(dir_q), .dat_i(dat_q), .own_i(own_q),
      .p_oe_i(periph_oe_i), .p_do_i(periph_do_i),
      .oe_o(pad_oe_o), .do_o(pad_do_o));

   gpio_rd_mux #(.W(PIN_W), .DIR_FILL(DIR_RD_FILL)) u_rd (
      .rd_i(bus_rd_i), .sel_i(sel), .dir_i(dir_q), .dat_i(dat_q),
      .sync_i(sync_q), .rdata_o(bus_rdata_o));

   a_r8_soft_drops_owner: assert property (@(posedge clk) disable iff (!rst_hard_n)
      rst_soft_i |=> own_q == '0);
   a_r3_dir_read_fill: assert property (@(posedge clk) disable iff (!rst_hard_n)
      (bus_rd_i && bus_addr_i == ADDR_DIR) |-> bus_rdata_o == DIR_RD_FILL);
   a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_hard_n)
      (bus_rd_i && bus_addr_i != ADDR_DIR && bus_addr_i != ADDR_DAT && bus_addr_i != ADDR_PIN)
      |-> bus_rdata_o == '0);
   a_r6_out_bits_from_data: assert property (@(posedge clk) disable iff (!rst_hard_n)
      (bus_rd_i && bus_addr_i == ADDR_PIN) |-> (bus_rdata_o & dir_q) == (dat_q & dir_q));
endmodule

// File: tb/gpio_byte_port_tb_top.sv
module gpio_byte_port_tb_top;
   localparam logic [15:0] A_DIR = 16'hFEB1;
   localparam logic [15:0] A_DAT = 16'hFF61;
   localparam logic [15:0] A_PIN = 16'hFF51;
   localparam logic [15:0] A_BAD = 16'h1234;

   logic clk = 1'b0;
   logic rst_hard_n = 1'b0, rst_soft = 1'b0;
   logic [15:0] addr = '0;
   logic wr = 1'b0, rd = 1'b0;
   logic [7:0] wdata = '0, rdata, pad_in = 8'hA5, oe, dout;
   logic [7:0] p_en = '0, p_oe = '0, p_do = '0;
   int n_chk = 0, n_fail = 0;
   logic [7:0] v;

   always #10 clk = ~clk;

   gpio_byte_port dut_i (
      .clk(clk), .rst_hard_n(rst_hard_n), .rst_soft_i(rst_soft),
      .bus_addr_i(addr), .bus_wr_i(wr), .bus_rd_i(rd), .bus_wdata_i(wdata),
      .bus_rdata_o(rdata), .pad_in_i(pad_in), .pad_oe_o(oe), .pad_do_o(dout),
      .periph_en_i(p_en), .periph_oe_i(p_oe), .periph_do_i(p_do));

   typedef struct packed {
      logic        is_wr;
      logic [15:0] addr;
      logic [7:0]  val;
      logic [7:0]  exp_oe;
      logic [7:0]  exp_do;
      logic [7:0]  exp_rd;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      '{1'b1, A_DIR, 8'hF0, 8'hF0, 8'h00, 8'h00},  // R2
      '{1'b1, A_DAT, 8'h3C, 8'hF0, 8'h3C, 8'h00},  // R4
      '{1'b0, A_DAT, 8'h00, 8'h00, 8'h00, 8'h3C},  // R4
      '{1'b0, A_DIR, 8'h00, 8'h00, 8'h00, 8'hFF},  // R3
      '{1'b0, A_PIN, 8'h00, 8'h00, 8'h00, 8'h35},  // R6
      '{1'b1, A_PIN, 8'h00, 8'hF0, 8'h3C, 8'h00},  // R9
      '{1'b1, A_BAD, 8'hFF, 8'hF0, 8'h3C, 8'h00},  // R9
      '{1'b0, A_BAD, 8'h00, 8'h00, 8'h00, 8'h00},  // R9
      '{1'b1, A_DIR, 8'h0F, 8'h0F, 8'h3C, 8'h00},  // R2
      '{1'b0, A_PIN, 8'h00, 8'h00, 8'h00, 8'hAC},  // R6
      '{1'b1, A_DAT, 8'hC3, 8'h0F, 8'hC3, 8'h00},  // R4
      '{1'b0, A_DAT, 8'h00, 8'h00, 8'h00, 8'hC3}   // R4
   };

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic read_now(input logic [15:0] a, output logic [7:0] r);
      addr = a; rd = 1'b1;
      #2 r = rdata;
      rd = 1'b0;
   endtask

   task automatic bus_read(input logic [15:0] a, output logic [7:0] r);
      @(negedge clk);
      read_now(a, r);
   endtask

   initial begin
      #(20 * 20000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: registers held clear during hard reset
      chk("R1 oe in reset", oe, 8'h00);
      chk("R1 do in reset", dout, 8'h00);
      rst_hard_n = 1'b1;
      bus_read(A_DAT, v); chk("R1 data after reset", v, 8'h00);
      repeat (2) @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         if (VECS[i].is_wr) begin
            bus_write(VECS[i].addr, VECS[i].val);
            chk($sformatf("vec%0d oe", i), oe, VECS[i].exp_oe);
            chk($sformatf("vec%0d do", i), dout, VECS[i].exp_do);
         end else begin
            bus_read(VECS[i].addr, v);
            chk($sformatf("vec%0d rdata", i), v, VECS[i].exp_rd);
         end
      end

      // R9: no read strobe -> zero
      @(negedge clk); addr = A_DAT; #2 chk("R9 idle rdata", rdata, 8'h00);

      // R6: synchronizer latency, dir=0F data=C3
      @(negedge clk); pad_in = 8'h55;
      @(negedge clk); read_now(A_PIN, v); chk("R6 one edge old level", v, 8'hA3);
      @(negedge clk); read_now(A_PIN, v); chk("R6 two edges new level", v, 8'h53);

      // R5: soft reset keeps registers
      @(negedge clk); rst_soft = 1'b1;
      @(negedge clk); rst_soft = 1'b0;
      chk("R5 oe kept", oe, 8'h0F);
      chk("R5 do kept", dout, 8'hC3);
      bus_read(A_DAT, v); chk("R5 data kept", v, 8'hC3);

      // R7: peripheral takes pins 7 and 0
      @(negedge clk); p_en = 8'h81; p_oe = 8'h80; p_do = 8'h80;
      #2 chk("R7 oe before edge", oe, 8'h0F);
      @(negedge clk);
      chk("R7 oe owned", oe, 8'h8E);
      chk("R7 do owned", dout, 8'hC2);

      // R8: soft reset drops ownership, request still held
      @(negedge clk); rst_soft = 1'b1;
      @(negedge clk); rst_soft = 1'b0;
      chk("R8 oe released", oe, 8'h0F);
      chk("R8 do released", dout, 8'hC3);
      @(negedge clk);
      chk("R7 oe reclaimed", oe, 8'h8E);
      p_en = 8'h00;
      @(negedge clk);
      chk("R7 oe after release", oe, 8'h0F);

      // R1: asynchronous hard reset mid-run
      @(negedge clk); rst_hard_n = 1'b0;
      #2 chk("R1 oe async clear", oe, 8'h00);
      chk("R1 do async clear", dout, 8'h00);
      @(negedge clk); rst_hard_n = 1'b1;
      bus_read(A_DAT, v); chk("R1 data cleared", v, 8'h00);
      bus_read(A_DIR, v); chk("R3 dir read after reset", v, 8'hFF);
      repeat (2) @(negedge clk);
      read_now(A_PIN, v); chk("R6 all inputs after reset", v, 8'h55);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule